// File: doc/BRIEF.md
# Fractional Baud Strobe Generator

This block produces the bit-rate strobe for a UART transmitter or receiver. A fixed base tick of 3 MHz is made by a clock enable that fires once every `TICK_DIV` system clocks; with the default of 16 this assumes a 48 MHz system clock. The base tick is then divided by a programmable divisor. The divisor has an integer part and a fractional part counted in eighths. Each strobe is one system clock wide.

The fraction is handled by a three-bit accumulator. At the start of every bit period the accumulator adds the fractional part. When that addition carries, the period is one base tick longer. Over any eight consecutive periods the total length is therefore exact.

Two integer values have a special meaning. Zero selects the full base rate, which is 3 MHz. One selects two thirds of it, which is 2 MHz, realised as periods of one and two base ticks in turn. For both of these values the fractional input is ignored. A new divisor value takes effect only at the next strobe, so the period already in progress always finishes at its old length.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, `baud_stb_o` is low.
- R2: Every strobe pulse on `baud_stb_o` is exactly one system clock wide.
- R3: Strobes fall only on base-tick boundaries. Consecutive strobes are always a whole multiple of `TICK_DIV` system clocks apart, and never closer than `TICK_DIV` clocks.
- R4: With an integer part n of 2 or more and a fraction of 0, every period is exactly n base ticks.
- R5: With n of 2 or more and a fraction f from 1 to 7 (f counts eighths; `div_frac_i` = f), every period is n or n+1 base ticks, and any eight consecutive periods total 8n+f base ticks.
- R6: With n = 1, periods alternate between 1 and 2 base ticks. Any eight consecutive periods total 12 base ticks, which averages 2 MHz when the base tick is 3 MHz.
- R7: With n = 0, a strobe follows every base tick.
- R8: When n is 0 or 1, `div_frac_i` has no effect on any period.
- R9: A change of `div_int_i` or `div_frac_i` during a period does not alter that period. The new value first applies to the period that starts at the next strobe.
- R10: The largest integer value, 2^INT_W-1, gives periods of exactly that many base ticks when the fraction is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| div_int_i | input | INT_W | Integer part n of the divisor (0 and 1 are the special rates) |
| div_frac_i | input | 3 | Fractional part of the divisor, in eighths |
| baud_stb_o | output | 1 | One-clock baud strobe |

## Verification
The bench builds the block with `TICK_DIV` = 2 and the default `INT_W` = 14. The short base tick keeps each base tick to two clocks, so a full eight-period window costs only a few hundred clocks for a small divisor. This also means the largest 14-bit divisor of 16383 can be timed over a whole period within the run. Every measured strobe spacing is converted back to base ticks, which lets the bench check on every period both the tick alignment and the bound of n or n+1.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int FRAC_W = 3;
  typedef logic [FRAC_W-1:0] frac_t;
  localparam frac_t FRAC_HALF = frac_t'(1 << (FRAC_W - 1));
endpackage

// File: rtl/fbg_tick_gen.sv
module fbg_tick_gen #(
  parameter int TICK_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/fbg_div_map.sv
module fbg_div_map
  import fbg_pkg::*;
#(
  parameter int INT_W = 14
) (
  input  logic [INT_W-1:0] int_i,
  input  frac_t            frac_i,
  output logic [INT_W-1:0] eff_int_o,
  output frac_t            eff_frac_o
);
  always_comb begin
    eff_int_o  = int_i;
    eff_frac_o = frac_i;
    if (int_i == '0) begin
      eff_int_o  = INT_W'(1);
      eff_frac_o = '0;
    end else if (int_i == INT_W'(1)) begin
      eff_int_o  = INT_W'(1);
      eff_frac_o = FRAC_HALF;
    end
  end
endmodule

// File: rtl/fbg_period_ctr.sv
module fbg_period_ctr
  import fbg_pkg::*;
#(
  parameter int INT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [INT_W-1:0] eff_int_i,
  input  frac_t            eff_frac_i,
  output logic             stb_o,
  output logic [INT_W:0]   len_o
);
  localparam int LW = INT_W + 1;

  logic [LW-1:0]   cnt_q, cnt_d, len_q, len_d;
  frac_t           acc_q, acc_d;
  logic            prime_q, prime_d, stb_q, stb_d;
  logic [FRAC_W:0] acc_sum;
  logic            wrap;

  always_comb begin
    wrap    = (cnt_q == len_q - 1'b1);
    acc_sum = {1'b0, acc_q} + {1'b0, eff_frac_i};
    cnt_d   = cnt_q;
    len_d   = len_q;
    acc_d   = acc_q;
    prime_d = prime_q;
    stb_d   = 1'b0;
    if (tick_i) begin
      if (wrap) begin
        cnt_d   = '0;
        acc_d   = acc_sum[FRAC_W-1:0];
        len_d   = {1'b0, eff_int_i} + {{INT_W{1'b0}}, acc_sum[FRAC_W]};
        prime_d = 1'b0;
        stb_d   = !prime_q;
      end else begin
        cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      len_q   <= LW'(1);
      acc_q   <= '0;
      prime_q <= 1'b1;
      stb_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      acc_q   <= acc_d;
      prime_q <= prime_d;
      stb_q   <= stb_d;
    end
  end

  assign stb_o = stb_q;
  assign len_o = len_q;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int INT_W    = 14,
  parameter int TICK_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] div_int_i,
  input  logic [2:0]       div_frac_i,
  output logic             baud_stb_o
);
  logic             rst_meta, rst_sync;
  logic             base_tick;
  logic [INT_W-1:0] eff_int;
  frac_t            eff_frac;
  logic [INT_W:0]   period_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  fbg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync),
    .tick_o (base_tick)
  );

  fbg_div_map #(.INT_W(INT_W)) u_map (
    .int_i      (div_int_i),
    .frac_i     (frac_t'(div_frac_i)),
    .eff_int_o  (eff_int),
    .eff_frac_o (eff_frac)
  );

  fbg_period_ctr #(.INT_W(INT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_sync),
    .tick_i     (base_tick),
    .eff_int_i  (eff_int),
    .eff_frac_i (eff_frac),
    .stb_o      (baud_stb_o),
    .len_o      (period_len)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int INT_W    = 14,
  parameter int TICK_DIV = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           stb,
  input logic [INT_W:0] len
);
  localparam int GW = $clog2(TICK_DIV + 1) + 1;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= GW'(TICK_DIV);
    else if (stb)                   gap_q <= GW'(1);
    else if (gap_q < GW'(TICK_DIV)) gap_q <= gap_q + 1'b1;
  end

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

  a_r3_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> $past(tick));

  a_r3_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (gap_q >= GW'(TICK_DIV)));

  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r9_len_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(len) |-> $past(tick));

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> !stb);
endmodule

bind frac_baud_gen fbg_checker #(.INT_W(INT_W), .TICK_DIV(TICK_DIV)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync),
  .tick  (base_tick),
  .stb   (baud_stb_o),
  .len   (period_len)
);

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  localparam int INT_W = 14;
  localparam int TD    = 2;
  localparam int NV    = 10;
  // n, f, expected ticks over 8 periods, min period, max period
  localparam int VEC [NV][5] = '{
    '{5, 0, 40, 5, 5},  '{2, 0, 16, 2, 2},   '{7, 3, 59, 7, 8},
    '{3, 7, 31, 3, 4},  '{10, 4, 84, 10, 11}, '{2, 1, 17, 2, 3},
    '{1, 0, 12, 1, 2},  '{1, 7, 12, 1, 2},   '{0, 0, 8, 1, 1},
    '{0, 6, 8, 1, 1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [INT_W-1:0] div_int = '0;
  logic [2:0]       div_frac = '0;
  logic             baud_stb;
  longint           cyc = 0;
  int               total = 0, bad = 0;
  bit               done = 0;

  frac_baud_gen #(.INT_W(INT_W), .TICK_DIV(TD)) i_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .div_int_i(div_int), .div_frac_i(div_frac),
    .baud_stb_o(baud_stb)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_stb(output longint t);
    @(negedge clk);
    while (!baud_stb) @(negedge clk);
    t = cyc;
    @(negedge clk);
    check(!baud_stb, "R2 width", 1, 0);
  endtask

  task automatic set_div(input int n, input int f);
    @(negedge clk);
    div_int  = INT_W'(n);
    div_frac = 3'(f);
  endtask

  initial begin
    longint t0, t1, d, sum;
    repeat (5) @(negedge clk);
    check(baud_stb == 1'b0, "R1 reset", baud_stb, 0);
    rst_n = 1'b1;

    // table walk: R4 R5 R6 R7 R8, spacing checks R3
    for (int i = 0; i < NV; i++) begin
      set_div(VEC[i][0], VEC[i][1]);
      wait_stb(t0);
      wait_stb(t0);
      sum = 0;
      for (int k = 0; k < 8; k++) begin
        wait_stb(t1);
        d = t1 - t0;
        t0 = t1;
        check((d % TD) == 0 && d >= TD, "R3 tick alignment", d, TD);
        check(d / TD >= VEC[i][3] && d / TD <= VEC[i][4],
              "R4/R5/R6/R7/R8 period bound", d / TD, VEC[i][3]);
        sum += d / TD;
      end
      check(sum == VEC[i][2], "R4/R5/R6/R7/R8 eight-period total", sum, VEC[i][2]);
    end

    // R9: change mid-period keeps the running period
    set_div(20, 0);
    wait_stb(t0);
    wait_stb(t0);
    repeat (10) @(negedge clk);
    div_int = INT_W'(3);
    wait_stb(t1);
    check(t1 - t0 == 20 * TD, "R9 old period kept", t1 - t0, 20 * TD);
    t0 = t1;
    wait_stb(t1);
    check(t1 - t0 == 3 * TD, "R9 new period applied", t1 - t0, 3 * TD);

    // R10: largest integer divisor
    set_div((1 << INT_W) - 1, 0);
    wait_stb(t0);
    wait_stb(t0);
    wait_stb(t1);
    check(t1 - t0 == ((1 << INT_W) - 1) * TD, "R10 max divisor", t1 - t0,
          ((1 << INT_W) - 1) * TD);

    // R1: reset again mid-run silences the strobe
    set_div(0, 0);
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    sum = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (baud_stb) sum++;
    end
    check(sum == 0, "R1 reset mid-run", sum, 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule